// File: doc/BRIEF.md
# DRAM Refresh Row Engine

This block is the refresh front end of a 2048-row asynchronous DRAM core, modelled on a fast sampling clock. It watches the active-low row strobe, column strobe and write strobe and works out from the order of their edges whether a refresh is requested. When the column strobe is already low as the row strobe falls, with the write strobe high, the engine refreshes the row held in its own wrapping row counter and then advances that counter. When the row strobe pulses low while the column strobe stays high the whole time, the row on the address pins is refreshed and the counter is left alone. A normal access, where the column strobe falls after the row strobe, produces no refresh.

Each refresh shows up as a one-cycle strobe together with the row to refresh and a flag that tells the array control logic whether the row came from the internal counter or from the pins. If a counter-driven refresh cycle keeps the row strobe low past an entry time, the engine drops into self-refresh. It then issues counter-driven refreshes from its own interval timer and raises a flag that also asks the data bus to float. The first sampled rising edge of the row strobe ends self-refresh. After that, the row strobe must stay high for a precharge time before the engine accepts a new cycle.

Top module: `refresh_engine`

## Requirements
- R1: After reset, refresh_stb, row_src_counter and self_refresh are 0, refresh_row is 0, and the first counter-driven refresh uses row 0.
- R2: If cas_n is sampled low in the cycle where ras_n is first sampled low, and we_n is high, a counter refresh starts. If ras_n then stays low for at least WE_HOLD_TICKS+1 sampled cycles, exactly one refresh_stb pulse follows, with row_src_counter=1 and refresh_row equal to the counter value.
- R3: The row counter is ROW_BITS wide. It advances by one after every counter-driven refresh, and from 2047 it wraps to 0.
- R4: If we_n is low when ras_n falls in a counter cycle, or is sampled low during the WE_HOLD_TICKS cycles after the fall, no refresh is issued and the counter is unchanged.
- R5: If cas_n stays high for the whole low pulse of ras_n, one refresh_stb pulse follows the rise of ras_n. It carries row_src_counter=0 and refresh_row equal to the addr value sampled as ras_n fell. The counter is unchanged.
- R6: No refresh is issued in two cases: cas_n falls while ras_n is low after a fall with cas_n high (a normal access), or a counter cycle holds ras_n low for WE_HOLD_TICKS cycles or fewer.
- R7: A counter cycle that keeps ras_n low for SR_ENTRY_TICKS cycles sets self_refresh to 1, which also requests a floating data bus.
- R8: During self-refresh, a counter-driven refresh is issued every SR_INTERVAL_TICKS cycles, with consecutive rows and row_src_counter=1.
- R9: Self-refresh ends on the first sampled rise of ras_n. The counter keeps its value, so the next counter refresh continues from it.
- R10: A fall of ras_n during the SR_PRECHG_TICKS cycles after the self-refresh exit is ignored and produces no refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ROW_BITS | Row address pins |
| refresh_stb | output | 1 | One-cycle refresh request |
| refresh_row | output | ROW_BITS | Row to refresh, held between requests |
| row_src_counter | output | 1 | 1 when refresh_row came from the internal counter, 0 when it came from the pins |
| self_refresh | output | 1 | Self-refresh active; the data bus is to float |

## Verification
The bench probes several edges. It holds ras_n low for exactly one cycle fewer and one cycle more than the write-hold window: a design that strobes early refreshes in an aborted cycle, and one that strobes late loses the refresh. It lets we_n drop inside the hold window and then checks the row of the next counter refresh, which shows a counter that slipped. It runs the counter through 2047 into 0, where a counter that saturates or is too wide gives the wrong row. It measures the spacing between self-refresh strobes, exits self-refresh, and at once sends a row-only pulse that must be ignored. A design that leaves self-refresh late or skips the precharge would either refresh that stray row or break the counter sequence.

// File: rtl/refr_pkg.sv
package refr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RO_PEND,
    ST_ACCESS,
    ST_CBR_HOLD,
    ST_CBR_LOW,
    ST_SELF,
    ST_PRECHG
  } refr_state_t;
endpackage

// File: rtl/refr_strobe_sampler.sv
module refr_strobe_sampler #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  output logic          ras_s,
  output logic          cas_s,
  output logic          we_s,
  output logic [AW-1:0] addr_s,
  output logic          ras_fall,
  output logic          ras_rise
);
  logic ras_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_s    <= 1'b1;
      cas_s    <= 1'b1;
      we_s     <= 1'b1;
      ras_prev <= 1'b1;
      addr_s   <= '0;
    end else begin
      ras_s    <= ras_n;
      cas_s    <= cas_n;
      we_s     <= we_n;
      ras_prev <= ras_s;
      addr_s   <= addr;
    end
  end

  assign ras_fall = ras_prev & ~ras_s;
  assign ras_rise = ~ras_prev & ras_s;
endmodule

// File: rtl/refr_tick_timer.sv
module refr_tick_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic done
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] count;

  assign done = en && (count == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (en) begin
      if (count == LAST) count <= '0;
      else               count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/refr_row_counter.sv
module refr_row_counter #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (inc) count <= count + 1'b1;
  end
endmodule

// File: rtl/refresh_engine.sv
module refresh_engine
  import refr_pkg::*;
#(
  parameter int ROW_BITS          = 11,
  parameter int WE_HOLD_TICKS     = 1,
  parameter int SR_ENTRY_TICKS    = 10000,
  parameter int SR_INTERVAL_TICKS = 6250,
  parameter int SR_PRECHG_TICKS   = 11
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ras_n,
  input  logic                cas_n,
  input  logic                we_n,
  input  logic [ROW_BITS-1:0] addr,
  output logic                refresh_stb,
  output logic [ROW_BITS-1:0] refresh_row,
  output logic                row_src_counter,
  output logic                self_refresh
);
  logic                ras_s, cas_s, we_s, ras_fall, ras_rise;
  logic [ROW_BITS-1:0] addr_s;
  logic [ROW_BITS-1:0] ctr_val;
  logic [ROW_BITS-1:0] ro_row_q;
  refr_state_t         state_q, state_d;
  logic                issue_ctr, issue_pin;
  logic                hold_done, entry_done, tick_done, prechg_done;
  logic                in_cbr, in_self, in_prechg;

  refr_strobe_sampler #(.AW(ROW_BITS)) sampler_i (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .ras_s(ras_s), .cas_s(cas_s), .we_s(we_s),
    .addr_s(addr_s), .ras_fall(ras_fall), .ras_rise(ras_rise)
  );

  refr_row_counter #(.W(ROW_BITS)) counter_i (
    .clk(clk), .rst(rst), .inc(issue_ctr), .count(ctr_val)
  );

  assign in_cbr    = (state_q == ST_CBR_HOLD) || (state_q == ST_CBR_LOW);
  assign in_self   = (state_q == ST_SELF);
  assign in_prechg = (state_q == ST_PRECHG);

  refr_tick_timer #(.LIMIT(WE_HOLD_TICKS)) hold_tmr_i (
    .clk(clk), .rst(rst), .clr(ras_fall),
    .en(state_q == ST_CBR_HOLD), .done(hold_done)
  );

  refr_tick_timer #(.LIMIT(SR_ENTRY_TICKS)) entry_tmr_i (
    .clk(clk), .rst(rst), .clr(ras_fall), .en(in_cbr), .done(entry_done)
  );

  refr_tick_timer #(.LIMIT(SR_INTERVAL_TICKS)) tick_tmr_i (
    .clk(clk), .rst(rst), .clr(!in_self), .en(in_self), .done(tick_done)
  );

  refr_tick_timer #(.LIMIT(SR_PRECHG_TICKS)) prechg_tmr_i (
    .clk(clk), .rst(rst), .clr(!in_prechg), .en(in_prechg), .done(prechg_done)
  );

  always_comb begin
    state_d   = state_q;
    issue_ctr = 1'b0;
    issue_pin = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ras_fall) begin
          if (cas_s)     state_d = ST_RO_PEND;
          else if (we_s) state_d = ST_CBR_HOLD;
          else           state_d = ST_ACCESS;
        end
      end
      ST_RO_PEND: begin
        if (ras_rise) begin
          issue_pin = 1'b1;
          state_d   = ST_IDLE;
        end else if (!cas_s) begin
          state_d = ST_ACCESS;
        end
      end
      ST_ACCESS: begin
        if (ras_rise) state_d = ST_IDLE;
      end
      ST_CBR_HOLD: begin
        if (ras_rise) begin
          state_d = ST_IDLE;
        end else if (!we_s) begin
          state_d = ST_ACCESS;
        end else if (hold_done) begin
          issue_ctr = 1'b1;
          state_d   = ST_CBR_LOW;
        end
      end
      ST_CBR_LOW: begin
        if (ras_rise)        state_d = ST_IDLE;
        else if (entry_done) state_d = ST_SELF;
      end
      ST_SELF: begin
        if (ras_rise) begin
          state_d = ST_PRECHG;
        end else if (tick_done) begin
          issue_ctr = 1'b1;
        end
      end
      ST_PRECHG: begin
        if (prechg_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q         <= ST_IDLE;
      ro_row_q        <= '0;
      refresh_stb     <= 1'b0;
      refresh_row     <= '0;
      row_src_counter <= 1'b0;
      self_refresh    <= 1'b0;
    end else begin
      state_q      <= state_d;
      refresh_stb  <= issue_ctr | issue_pin;
      self_refresh <= (state_d == ST_SELF);
      if ((state_q == ST_IDLE) && ras_fall && cas_s) ro_row_q <= addr_s;
      if (issue_ctr) begin
        refresh_row     <= ctr_val;
        row_src_counter <= 1'b1;
      end else if (issue_pin) begin
        refresh_row     <= ro_row_q;
        row_src_counter <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/refresh_engine_chk.sv
module refresh_engine_chk
  import refr_pkg::*;
#(
  parameter int ROW_BITS = 11
) (
  input logic                clk,
  input logic                rst,
  input logic                refresh_stb,
  input logic [ROW_BITS-1:0] refresh_row,
  input logic                row_src_counter,
  input logic                self_refresh,
  input logic [ROW_BITS-1:0] ctr_val,
  input logic                ras_s,
  input logic                cas_s,
  input logic                ras_rise,
  input refr_state_t         state_q
);
  // R2: each refresh request lasts a single cycle
  assert_stb_single_R2: assert property (@(posedge clk) disable iff (rst)
    refresh_stb |=> !refresh_stb);

  // R3: the counter has moved one past the row just issued
  assert_ctr_advance_R3: assert property (@(posedge clk) disable iff (rst)
    (refresh_stb && row_src_counter) |-> (ctr_val == ROW_BITS'(refresh_row + 1'b1)));

  // R5: a pin-sourced refresh leaves the counter alone
  assert_pin_keeps_ctr_R5: assert property (@(posedge clk) disable iff (rst)
    (refresh_stb && !row_src_counter) |-> $stable(ctr_val));

  // R7: self-refresh is entered only with both strobes held low
  assert_sr_entry_cbr_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(self_refresh) |-> (!$past(cas_s) && !$past(ras_s)));

  // R8: self-refresh requests always use the counter
  assert_sr_ctr_src_R8: assert property (@(posedge clk) disable iff (rst)
    (refresh_stb && self_refresh) |-> row_src_counter);

  // R9: a rising row strobe ends self-refresh in the next cycle
  assert_sr_exit_R9: assert property (@(posedge clk) disable iff (rst)
    (self_refresh && ras_rise) |=> !self_refresh);

  // R10: no request during the post-exit precharge window
  assert_prechg_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PRECHG) |-> !refresh_stb);
endmodule

bind refresh_engine refresh_engine_chk #(.ROW_BITS(ROW_BITS)) chk_i (
  .clk(clk), .rst(rst), .refresh_stb(refresh_stb), .refresh_row(refresh_row),
  .row_src_counter(row_src_counter), .self_refresh(self_refresh),
  .ctr_val(ctr_val), .ras_s(ras_s), .cas_s(cas_s), .ras_rise(ras_rise),
  .state_q(state_q)
);

// File: tb/refresh_engine_tb_top.sv
module refresh_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RB       = 11;
  localparam int ROWS     = 1 << RB;
  localparam int HOLD     = 3;
  localparam int ENTRY    = 40;
  localparam int INTERVAL = 25;
  localparam int PRECHG   = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [RB-1:0] addr = '0;
  logic refresh_stb, row_src_counter, self_refresh;
  logic [RB-1:0] refresh_row;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  int ns = 0;
  int exp_ctr = 0;
  bit finished = 0;
  int hist_row [64];
  int hist_src [64];
  int hist_cyc [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  refresh_engine #(
    .ROW_BITS(RB), .WE_HOLD_TICKS(HOLD), .SR_ENTRY_TICKS(ENTRY),
    .SR_INTERVAL_TICKS(INTERVAL), .SR_PRECHG_TICKS(PRECHG)
  ) dut_i (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .refresh_stb(refresh_stb), .refresh_row(refresh_row),
    .row_src_counter(row_src_counter), .self_refresh(self_refresh)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && refresh_stb) begin
      hist_row[ns % 64] = int'(refresh_row);
      hist_src[ns % 64] = int'(row_src_counter);
      hist_cyc[ns % 64] = cyc;
      ns = ns + 1;
    end
  end

  function automatic int next_row(input int r);
    return (r + 1) % ROWS;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cbr(input int low, input bit we_drop, input bit we_early);
    cas_n = 1'b0; we_n = we_early ? 1'b0 : 1'b1;
    idle(2);
    ras_n = 1'b0;
    if (we_drop) begin idle(1); we_n = 1'b0; idle(low - 1); end
    else idle(low);
    ras_n = 1'b1;
    idle(2);
    cas_n = 1'b1; we_n = 1'b1;
    idle(4);
  endtask

  task automatic ras_only(input int a, input int low);
    addr = RB'(a); cas_n = 1'b1;
    idle(1);
    ras_n = 1'b0;
    idle(low);
    ras_n = 1'b1;
    idle(4);
  endtask

  task automatic access(input int low);
    ras_n = 1'b0; idle(2);
    cas_n = 1'b0; idle(low);
    ras_n = 1'b1; idle(1);
    cas_n = 1'b1; idle(4);
  endtask

  task automatic expect_ctr_refresh(input string req, input int n0);
    chk(req, ns - n0, 1);
    chk(req, hist_row[(ns - 1) % 64], exp_ctr);
    chk(req, hist_src[(ns - 1) % 64], 1);
    exp_ctr = next_row(exp_ctr);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int n0, op, a, low, d;
    void'($urandom(32'd2718));
    idle(4);
    rst = 1'b0;
    idle(2);
    // R1: reset state
    chk("R1 stb", int'(refresh_stb), 0);
    chk("R1 src", int'(row_src_counter), 0);
    chk("R1 self", int'(self_refresh), 0);
    chk("R1 row", int'(refresh_row), 0);
    n0 = ns; cbr(8, 0, 0); expect_ctr_refresh("R1 first row", n0);

    // R2/R6: boundary of the write-hold window
    n0 = ns; cbr(HOLD, 0, 0); chk("R6 short cbr", ns - n0, 0);
    n0 = ns; cbr(HOLD + 1, 0, 0); expect_ctr_refresh("R2 min low", n0);

    // R4: write strobe violations
    n0 = ns; cbr(10, 1, 0); chk("R4 we drop", ns - n0, 0);
    n0 = ns; cbr(10, 0, 1); chk("R4 we early", ns - n0, 0);
    n0 = ns; cbr(8, 0, 0); expect_ctr_refresh("R4 ctr kept", n0);

    // R5/R6 directed
    n0 = ns; ras_only(1234, 5);
    chk("R5 count", ns - n0, 1);
    chk("R5 row", hist_row[(ns - 1) % 64], 1234);
    chk("R5 src", hist_src[(ns - 1) % 64], 0);
    n0 = ns; access(4); chk("R6 access", ns - n0, 0);
    n0 = ns; cbr(8, 0, 0); expect_ctr_refresh("R5 ctr unchanged", n0);

    // random mix
    for (int i = 0; i < 300; i++) begin
      op = int'($urandom() % 6);
      n0 = ns;
      case (op)
        0: begin low = 8 + int'($urandom() % 8); cbr(low, 0, 0); expect_ctr_refresh("R2 rand", n0); end
        1: begin
          a = int'($urandom() % ROWS); low = 3 + int'($urandom() % 6);
          ras_only(a, low);
          chk("R5 rand count", ns - n0, 1);
          chk("R5 rand row", hist_row[(ns - 1) % 64], a);
          chk("R5 rand src", hist_src[(ns - 1) % 64], 0);
        end
        2: begin access(2 + int'($urandom() % 5)); chk("R6 rand access", ns - n0, 0); end
        3: begin cbr(1 + int'($urandom() % HOLD), 0, 0); chk("R6 rand short", ns - n0, 0); end
        4: begin cbr(10, 1, 0); chk("R4 rand drop", ns - n0, 0); end
        default: begin cbr(10, 0, 1); chk("R4 rand early", ns - n0, 0); end
      endcase
    end

    // R3: wrap from the last row to zero
    while (exp_ctr != ROWS - 1) begin
      n0 = ns; cbr(5, 0, 0);
      chk("R3 step", ns - n0, 1);
      exp_ctr = next_row(exp_ctr);
    end
    n0 = ns; cbr(5, 0, 0); expect_ctr_refresh("R3 last row", n0);
    n0 = ns; cbr(5, 0, 0); expect_ctr_refresh("R3 wrap zero", n0);

    // R7/R8/R9: self-refresh
    n0 = ns;
    cas_n = 1'b0; we_n = 1'b1; idle(2);
    ras_n = 1'b0; idle(150);
    chk("R7 self active", int'(self_refresh), 1);
    idle(50);
    ras_n = 1'b1; cas_n = 1'b1;
    idle(2);
    chk("R9 exit", int'(self_refresh), 0);
    d = ns - n0;
    chk("R8 enough", int'(d >= 5), 1);
    for (int k = 0; k < d; k++) begin
      chk("R8 row", hist_row[(n0 + k) % 64], (exp_ctr + k) % ROWS);
      chk("R8 src", hist_src[(n0 + k) % 64], 1);
      if (k >= 2)
        chk("R8 spacing", hist_cyc[(n0 + k) % 64] - hist_cyc[(n0 + k - 1) % 64], INTERVAL);
    end
    exp_ctr = (exp_ctr + d) % ROWS;

    // R10: row pulse inside the precharge window is ignored
    n0 = ns;
    ras_n = 1'b0; idle(2);
    ras_n = 1'b1; idle(PRECHG + 6);
    chk("R10 ignored", ns - n0, 0);
    n0 = ns; ras_only(77, 4);
    chk("R10 after window", ns - n0, 1);
    chk("R10 row", hist_row[(ns - 1) % 64], 77);
    n0 = ns; cbr(8, 0, 0); expect_ctr_refresh("R9 ctr kept", n0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule